// File: doc/BRIEF.md
# Monitored-Load Region Event Detector

This block sits beside the load pipeline of a processor core and watches every load as it issues. Software describes one memory region, sized as a power of two between 32 MB and 1 TB and aligned to its own size, and splits it into 64 equal sections. Each section can be switched on or off independently. A load marked as "monitored" that reads from a switched-on section, while monitoring is armed, makes the block request an event-based branch. The same cycle, the block tells the pipeline to hold back completion and register writeback for that load, so that a handler can fix the pointer in memory and the load can run again.

Ordinary loads never raise the event. Once the event is taken, the block disarms itself and records that an event occurred, in a single step. Software re-arms it by writing the control bits. A single write port updates the region, the section enables and the control bits. A write takes effect on the next clock edge, so a load checked in the cycle of the write still sees the old values.

Top module: `ldmon_detector`

## Requirements
- R1: The region write (cfgSel = 0) takes a size code n in bits [3:0], giving a region of 2^(25+n) bytes, and the base in bits [63:25]; base bits below 25+n are ignored, so the region is always aligned to its own size.
- R2: The section index of an address is address bits [24+n : 19+n], and section i is enabled by bit i of the section-enable register (cfgSel = 1).
- R3: Monitoring is armed only when both the global-enable bit and the monitor-enable bit are 1; no event is raised otherwise.
- R4: evtBranchReq is high, in the same cycle, exactly when a valid monitored load hits an enabled section of the region while monitoring is armed.
- R5: On the edge after an event, monitor-enable reads 0 and monitor-occurred reads 1, and global-enable is unchanged; these two bits take the event's values even when a control write lands in the same cycle.
- R6: A valid load with ldMonitored low never raises an event, whatever its address.
- R7: ldSuppress equals evtBranchReq, and ldWriteback is high for a valid load exactly when no event is raised for it.
- R8: While monitor-enable is 0, monitored loads into enabled sections raise no event and leave monitor-occurred unchanged.
- R9: A write with cfgWrEn high updates the selected register on the next edge; a load in the same cycle is checked against the old values; cfgSel = 2 writes the control bits (bit 2 global-enable, bit 1 monitor-enable, bit 0 monitor-occurred); cfgSel = 3 changes nothing.
- R10: After reset, all three control bits are 0 and no event can fire until software configures the block.
- R11: After software writes monitor-enable = 1 and monitor-occurred = 0, the block is armed again, and a re-run monitored load whose address lies outside every enabled section completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | A load is presented this cycle |
| ldMonitored | input | 1 | The load is of the monitored variant |
| ldAddr | input | 64 | Effective address of the load |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 region, 1 section enables, 2 control, 3 none |
| cfgWrData | input | 64 | Register write data |
| evtBranchReq | output | 1 | Event-based branch request |
| ldSuppress | output | 1 | Hold back completion of the current load |
| ldWriteback | output | 1 | Register writeback allowed for the current load |
| ctlGlobalEn | output | 1 | Global-enable bit |
| ctlMonEn | output | 1 | Monitor-enable bit |
| ctlMonOccur | output | 1 | Monitor-occurred bit |

## Verification
A corrupted base or size register shows on the very next monitored load near the region. The load either raises a branch request it should not, or misses one, and the result is visible in the same cycle at evtBranchReq and ldWriteback. A stale or flipped section bit shows the same way, but only when a load reaches that one section. For this reason the random stimulus keeps addresses close to the configured region. A wrong control-bit state is visible at the control outputs one edge after the event or write that caused it, and it also changes whether the next monitored load triggers.

// File: rtl/ldmon_pkg.sv
package ldmon_pkg;
  localparam int ADDR_W   = 64;
  localparam int SECT_LOG = 6;
  localparam int MIN_LOG  = 25;
  localparam int SIZE_W   = 4;

  typedef enum logic [1:0] {
    SEL_REGION  = 2'd0,
    SEL_SECTION = 2'd1,
    SEL_CTL     = 2'd2,
    SEL_NONE    = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic wrRegion;
    logic wrSection;
  } dpStrobe_t;
endpackage

// File: rtl/ldmon_datapath.sv
module ldmon_datapath
  import ldmon_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int SL  = SECT_LOG,
  parameter int ML  = MIN_LOG,
  parameter int SW  = SIZE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] wrData,
  input  logic [AW-1:0] ldAddr,
  output logic          regionHit,
  output logic          sectionOn
);
  localparam int SECTS = 1 << SL;
  localparam int SH_W  = $clog2(AW) + 1;

  logic [AW-1:ML]   baseQ;
  logic [SW-1:0]    sizeQ;
  logic [SECTS-1:0] sectQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      sizeQ <= '0;
      sectQ <= '0;
    end else begin
      if (strobe.wrRegion) begin
        baseQ <= wrData[AW-1:ML];
        sizeQ <= wrData[SW-1:0];
      end
      if (strobe.wrSection) sectQ <= wrData[SECTS-1:0];
    end
  end

  logic [SH_W-1:0] regionLog;
  logic [SH_W-1:0] sectLog;
  logic [AW-1:0]   highMask;
  logic [AW-1:0]   baseFull;
  logic [AW-1:0]   shifted;
  logic [SL-1:0]   sectIdx;

  always_comb begin
    regionLog = SH_W'(ML) + SH_W'(sizeQ);
    sectLog   = regionLog - SH_W'(SL);
    highMask  = {AW{1'b1}} << regionLog;
    baseFull  = {baseQ, {ML{1'b0}}};
    regionHit = ((ldAddr ^ baseFull) & highMask) == '0;
    shifted   = ldAddr >> sectLog;
    sectIdx   = shifted[SL-1:0];
  end

  logic [SECTS-1:0] sectMatch;
  for (genvar i = 0; i < SECTS; i++) begin : g_sect
    assign sectMatch[i] = sectQ[i] && (sectIdx == SL'(i));
  end
  assign sectionOn = |sectMatch;

  // R2: at most one section decodes as selected
  assert_one_section_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sectMatch));
  // R9: region registers hold when no region write arrives
  assert_region_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrRegion |=> $stable(baseQ) && $stable(sizeQ));
endmodule

// File: rtl/ldmon_ctrl.sv
module ldmon_ctrl
  import ldmon_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic [2:0] ctlData,
  input  logic      ldValid,
  input  logic      ldMonitored,
  input  logic      regionHit,
  input  logic      sectionOn,
  output dpStrobe_t strobe,
  output logic      evtBranchReq,
  output logic      ldSuppress,
  output logic      ldWriteback,
  output logic      globalEn,
  output logic      monEn,
  output logic      monOccur
);
  logic armed;
  logic wrCtl;
  logic gNext, mNext, oNext;

  always_comb begin
    strobe.wrRegion  = cfgWrEn && (cfgSel == SEL_REGION);
    strobe.wrSection = cfgWrEn && (cfgSel == SEL_SECTION);
    wrCtl            = cfgWrEn && (cfgSel == SEL_CTL);
    armed            = globalEn && monEn;
    evtBranchReq     = ldValid && ldMonitored && armed && regionHit && sectionOn;
    ldSuppress       = evtBranchReq;
    ldWriteback      = ldValid && !evtBranchReq;

    gNext = wrCtl ? ctlData[2] : globalEn;
    mNext = wrCtl ? ctlData[1] : monEn;
    oNext = wrCtl ? ctlData[0] : monOccur;
    if (evtBranchReq) begin
      mNext = 1'b0;
      oNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      monEn    <= 1'b0;
      monOccur <= 1'b0;
    end else begin
      globalEn <= gNext;
      monEn    <= mNext;
      monOccur <= oNext;
    end
  end

  // R5: taking the event disarms and records the occurrence
  assert_take_flips_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtBranchReq |=> !monEn && monOccur);
  // R5: global enable survives the event when nothing rewrites it
  assert_global_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtBranchReq && !wrCtl |=> $stable(globalEn));
  // R6: plain loads are never flagged
  assert_plain_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ldValid && !ldMonitored |-> !evtBranchReq);
  // R7: the faulting load gets no writeback
  assert_no_writeback_R7: assert property (@(posedge clk) disable iff (!rstN)
    evtBranchReq |-> ldSuppress && !ldWriteback);
  // R8: occurred flag holds while disarmed and untouched
  assert_occur_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !monEn && !wrCtl |=> $stable(monOccur));
endmodule

// File: rtl/ldmon_detector.sv
module ldmon_detector
  import ldmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldValid,
  input  logic        ldMonitored,
  input  logic [63:0] ldAddr,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgSel,
  input  logic [63:0] cfgWrData,
  output logic        evtBranchReq,
  output logic        ldSuppress,
  output logic        ldWriteback,
  output logic        ctlGlobalEn,
  output logic        ctlMonEn,
  output logic        ctlMonOccur
);
  dpStrobe_t strobe;
  logic      regionHit;
  logic      sectionOn;

  ldmon_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (cfgWrData),
    .ldAddr    (ldAddr),
    .regionHit (regionHit),
    .sectionOn (sectionOn)
  );

  ldmon_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgSel       (cfgSel),
    .ctlData      (cfgWrData[2:0]),
    .ldValid      (ldValid),
    .ldMonitored  (ldMonitored),
    .regionHit    (regionHit),
    .sectionOn    (sectionOn),
    .strobe       (strobe),
    .evtBranchReq (evtBranchReq),
    .ldSuppress   (ldSuppress),
    .ldWriteback  (ldWriteback),
    .globalEn     (ctlGlobalEn),
    .monEn        (ctlMonEn),
    .monOccur     (ctlMonOccur)
  );

  // R3: no event unless both enables were set
  assert_armed_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    evtBranchReq |-> ctlGlobalEn && ctlMonEn);
endmodule

// File: tb/sim_ldmon_detector.sv
module sim_ldmon_detector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0, ldMonitored = 1'b0;
  logic [63:0] ldAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [63:0] cfgWrData = '0;
  logic        evtBranchReq, ldSuppress, ldWriteback;
  logic        ctlGlobalEn, ctlMonEn, ctlMonOccur;

  always #2.5 clk = ~clk;

  ldmon_detector u0 (.*);

  int tests = 0;
  int fails = 0;

  // bench model
  logic [63:0] mBase = '0;
  logic [3:0]  mN = '0;
  logic [63:0] mSect = '0;
  logic        mG = 0, mM = 0, mO = 0;

  function automatic logic inSection(logic [63:0] a);
    int sh = 25 + int'(mN);
    logic [63:0] d = (a ^ mBase) >> sh;
    logic [63:0] idx = (a >> (sh - 6)) & 64'd63;
    return (d == 0) && mSect[idx[5:0]];
  endfunction

  function automatic logic expEvent(logic v, logic m, logic [63:0] a);
    return v && m && mG && mM && inSection(a);
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic m, logic [63:0] a,
                      logic we, logic [1:0] sel, logic [63:0] d);
    logic e;
    @(negedge clk);
    ldValid = v; ldMonitored = m; ldAddr = a;
    cfgWrEn = we; cfgSel = sel; cfgWrData = d;
    #1;
    e = expEvent(v, m, a);
    check("R4 event", evtBranchReq, e);
    check("R7 suppress", ldSuppress, e);
    check("R7 writeback", ldWriteback, v && !e);
    check("R5 globalEn", ctlGlobalEn, mG);
    check("R5 monEn", ctlMonEn, mM);
    check("R8 monOccur", ctlMonOccur, mO);
    @(posedge clk);
    if (we) begin
      case (sel)
        2'd0: begin mBase = d & ~64'h1FF_FFFF; mN = d[3:0]; end
        2'd1: mSect = d;
        2'd2: begin mG = d[2]; mM = d[1]; mO = d[0]; end
        default: ;
      endcase
    end
    if (e) begin mM = 0; mO = 1; end
  endtask

  task automatic load(logic m, logic [63:0] a);
    step(1'b1, m, a, 1'b0, 2'd0, '0);
  endtask

  task automatic wr(logic [1:0] sel, logic [63:0] d);
    step(1'b0, 1'b0, '0, 1'b1, sel, d);
  endtask

  localparam logic [63:0] B0 = 64'h0000_0001_0200_0000; // 32 MB aligned
  localparam logic [63:0] B15 = 64'h0000_0300_0000_0000; // 1 TB aligned

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R10: reset state, nothing fires unconfigured
    #1;
    check("R10 gEn", ctlGlobalEn, 1'b0);
    check("R10 mEn", ctlMonEn, 1'b0);
    check("R10 occ", ctlMonOccur, 1'b0);
    load(1'b1, 64'h0);
    check("R10 no event", evtBranchReq, 1'b0);

    // configure n=0 region, section 5, arm
    wr(2'd0, B0 | 64'h0);
    wr(2'd1, 64'h1 << 5);
    wr(2'd2, 64'b110);
    // R4: hit section 5 (bits [24:19])
    load(1'b1, B0 + (64'd5 << 19) + 64'd8);
    // R5: state after event
    #1;
    check("R5 mEn cleared", ctlMonEn, 1'b0);
    check("R5 occ set", ctlMonOccur, 1'b1);
    check("R5 gEn kept", ctlGlobalEn, 1'b1);
    // R8: disarmed, no event
    load(1'b1, B0 + (64'd5 << 19));
    check("R8 no event", evtBranchReq, 1'b0);
    // R11: re-arm and re-run outside enabled sections
    wr(2'd2, 64'b110);
    load(1'b1, B0 + (64'd6 << 19));
    check("R11 completes", ldWriteback, 1'b1);
    // R6: ordinary load into enabled section
    load(1'b0, B0 + (64'd5 << 19));
    // R9: same-cycle section clear uses old enables -> event
    step(1'b1, 1'b1, B0 + (64'd5 << 19), 1'b1, 2'd1, 64'h0);
    wr(2'd2, 64'b110);
    load(1'b1, B0 + (64'd5 << 19)); // now cleared -> no event
    // R9: select 3 changes nothing
    wr(2'd1, 64'h1 << 5);
    wr(2'd3, 64'h0);
    load(1'b1, B0 + (64'd5 << 19));
    // R5: event beats same-cycle control write
    wr(2'd2, 64'b110);
    step(1'b1, 1'b1, B0 + (64'd5 << 19), 1'b1, 2'd2, 64'b110);
    // R1/R2: 1 TB region with junk low base bits, top section
    wr(2'd0, B15 | 64'h0000_00AB_CE00_0000 | 64'hF);
    wr(2'd1, 64'h1 << 63);
    wr(2'd2, 64'b110);
    load(1'b1, B15 + (64'd63 << 34) + 64'h10);
    wr(2'd2, 64'b110);
    load(1'b1, B15 + (64'd1 << 40) + (64'd63 << 34)); // just outside
    load(1'b1, B15 + (64'd62 << 34));
    // R3: global enable off blocks event
    wr(2'd2, 64'b010);
    load(1'b1, B15 + (64'd63 << 34));

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) begin
        logic [3:0] n = 4'($urandom_range(0, 15));
        logic [63:0] b = {$urandom(), $urandom()} & 64'h0000_0FFF_FFFF_FFFF;
        b = b & ~((64'd1 << (25 + n)) - 1);
        step(1'b0, 1'b0, '0, 1'b1, 2'd0, b | {60'd0, n} | 64'h0100_0000);
      end else if (r < 6) begin
        step(1'b0, 1'b0, '0, 1'b1, 2'd1, {$urandom(), $urandom()});
      end else if (r < 14) begin
        step(1'b1, 1'($urandom_range(0, 1)), mBase, 1'b1, 2'(2 + $urandom_range(0, 1)),
             64'($urandom_range(0, 7)));
      end else begin
        int sh = 25 + int'(mN);
        logic [63:0] off = {$urandom(), $urandom()} & ((64'd1 << (sh + 1)) - 1);
        step(1'($urandom_range(0, 9) != 0), 1'($urandom_range(0, 3) != 0),
             mBase + off, 1'b0, 2'd0, '0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule